// File: doc/BRIEF.md
# Power-Stage Protection and Reset Supervisor

This block is the digital supervisor for a switching power stage with four half-bridges. The bridges are numbered 0 to 3. Bridges 0 and 1 form the first group and bridges 2 and 3 form the second. Each group has its own active-low reset input. Holding a group reset low mutes that group by putting both of its transistors into high impedance.

The supervisor also watches three kinds of fault:
- per-supply undervoltage flags,
- an 8-bit junction-temperature code,
- per-bridge overcurrent flags.

It drives a per-bridge high-impedance enable and a per-bridge weak-pulldown enable. It also drives an active-low fault output and an active-low overtemperature warning.

The faults clear in different ways:
- An undervoltage fault releases on its own once the supplies recover.
- A thermal shutdown stays latched until both group resets are low at the same time.
- An overload stays latched until a rising edge on either group reset.

Every input passes through a two-stage synchronizer. Every output is registered. An input change therefore reaches the outputs on the third rising clock edge after it is applied.

Top module: `pg_supervisor`

## Requirements
- R1: While `grpRstAbN` is 0, `hizEn[1:0]` are both 1. If no fault is present, `hizEn[3:2]` stay 0.
- R2: While `grpRstCdN` is 0, `hizEn[3:2]` are both 1. If no fault is present, `hizEn[1:0]` stay 0.
- R3: While any bit of `uvFlag` is 1 (1 = supply below threshold), `hizEn` is 4'hF. In the same condition, `sdN` is 0 when both group resets are high.
- R4: The undervoltage condition clears when all `uvFlag` bits return to 0, and outputs go back to normal with no reset needed. Any undervoltage also clears a latched overload.
- R5: `otwN` goes to 0 when `tempCode` is above 125. It returns to 1 only when `tempCode` is 115 or less, and holds its value for codes from 116 to 125.
- R6: A `tempCode` above 155 latches a thermal shutdown. During the shutdown `hizEn` is 4'hF and `sdN` is 0 (when both resets are high). The shutdown persists after the temperature falls.
- R7: The thermal shutdown latch clears only while both group resets are 0 together. A low on one reset alone leaves it set.
- R8: A 1 on any bit of `ocFlag` latches an overload. The overload forces `hizEn` to 4'hF and `sdN` to 0, and it is held after the flag drops. It clears on a rising edge of either group reset.
- R9: While either group reset is 0, `sdN` is 1 whatever faults are present.
- R10: With `modeSe` at 0 (bridged mode), `pullEn` is 1 for the bridges of every group whose reset is 0. With `modeSe` at 1 (single-ended mode), `pullEn` is always 0.
- R11: While `rstN` is 0, the outputs are `hizEn`=4'hF, `pullEn`=0, `sdN`=1 and `otwN`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| grpRstAbN | input | 1 | Active-low reset and mute for bridges 0 and 1 |
| grpRstCdN | input | 1 | Active-low reset and mute for bridges 2 and 3 |
| uvFlag | input | 2 | Undervoltage flag per supply, 1 = below threshold |
| tempCode | input | 8 | Junction temperature, unsigned, in degrees C |
| ocFlag | input | 4 | Overcurrent flag per bridge |
| modeSe | input | 1 | Output mode: 0 = bridged, 1 = single-ended |
| hizEn | output | 4 | High-impedance enable per bridge |
| pullEn | output | 4 | Weak-pulldown enable per bridge |
| sdN | output | 1 | Active-low shutdown/fault report |
| otwN | output | 1 | Active-low overtemperature warning |

## Verification
The assertions assume that `tempCode` is stable whenever it is captured. The code is multi-bit and is only passed through two register stages, so the design takes it as quasi-static. They also assume that every reset pulse and fault flag lasts longer than the synchronizer depth, so that no edge is lost. The stimulus changes the inputs only on falling clock edges. It then holds each setting for at least five cycles before the next change, which meets both assumptions and leaves the three-edge latency settled before each comparison.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef struct packed {
    logic abLow;
    logic cdLow;
    logic bothLow;
    logic rstRise;
    logic anyUv;
    logic anyOc;
    logic overWarn;
    logic underWarn;
    logic overShut;
    logic modeSe;
  } pgStrobe_t;
endpackage

// File: rtl/pg_datapath.sv
module pg_datapath
  import pg_pkg::*;
#(
  parameter int NUM_SUP  = 2,
  parameter int NUM_BR   = 4,
  parameter int TEMP_W   = 8,
  parameter int WARN_ON  = 125,
  parameter int WARN_OFF = 115,
  parameter int SHUT_ON  = 155
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grpRstAbN,
  input  logic              grpRstCdN,
  input  logic [NUM_SUP-1:0] uvFlag,
  input  logic [NUM_BR-1:0] ocFlag,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic              modeSe,
  output pgStrobe_t         strb
);
  localparam int SYNC_W = 2 + NUM_SUP + NUM_BR + 1;
  localparam logic [SYNC_W-1:0] SYNC_INIT = {2'b00, {NUM_SUP{1'b1}}, {NUM_BR{1'b0}}, 1'b0};
  localparam logic [TEMP_W-1:0] WARN_ON_C  = TEMP_W'(WARN_ON);
  localparam logic [TEMP_W-1:0] WARN_OFF_C = TEMP_W'(WARN_OFF);
  localparam logic [TEMP_W-1:0] SHUT_ON_C  = TEMP_W'(SHUT_ON);

  logic [SYNC_W-1:0] rawIn, syncA, syncB;
  logic [TEMP_W-1:0] tempA, tempB;
  logic [1:0]        rstPrev;
  logic              abQ, cdQ, seQ;
  logic [NUM_SUP-1:0] uvQ;
  logic [NUM_BR-1:0] ocQ;

  assign rawIn = {grpRstAbN, grpRstCdN, uvFlag, ocFlag, modeSe};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= SYNC_INIT;
      syncB   <= SYNC_INIT;
      tempA   <= '0;
      tempB   <= '0;
      rstPrev <= 2'b00;
    end else begin
      syncA   <= rawIn;
      syncB   <= syncA;
      tempA   <= tempCode;
      tempB   <= tempA;
      rstPrev <= {abQ, cdQ};
    end
  end

  assign abQ = syncB[SYNC_W-1];
  assign cdQ = syncB[SYNC_W-2];
  assign uvQ = syncB[NUM_BR+1 +: NUM_SUP];
  assign ocQ = syncB[1 +: NUM_BR];
  assign seQ = syncB[0];

  always_comb begin
    strb.abLow     = ~abQ;
    strb.cdLow     = ~cdQ;
    strb.bothLow   = ~abQ & ~cdQ;
    strb.rstRise   = (abQ & ~rstPrev[1]) | (cdQ & ~rstPrev[0]);
    strb.anyUv     = |uvQ;
    strb.anyOc     = |ocQ;
    strb.overWarn  = tempB > WARN_ON_C;
    strb.underWarn = tempB <= WARN_OFF_C;
    strb.overShut  = tempB > SHUT_ON_C;
    strb.modeSe    = seQ;
  end

  AST_SHUT_IMPLIES_WARN: assert property (@(posedge clk) disable iff (!rstN)
    strb.overShut |-> strb.overWarn); // R6
  AST_WARN_BANDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.overWarn && strb.underWarn)); // R5
endmodule

// File: rtl/pg_control.sv
module pg_control
  import pg_pkg::*;
#(
  parameter int NUM_BR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobe_t         strb,
  output logic [NUM_BR-1:0] hizEn,
  output logic [NUM_BR-1:0] pullEn,
  output logic              sdN,
  output logic              otwN
);
  localparam int HALF = NUM_BR / 2;

  logic otLatch, olLatch, otwReg;
  logic nextOt, nextOl, nextOtw, fault;
  logic [NUM_BR-1:0] grpLow;

  for (genvar i = 0; i < NUM_BR; i++) begin : g_grp
    if (i < HALF) begin : g_ab
      assign grpLow[i] = strb.abLow;
    end else begin : g_cd
      assign grpLow[i] = strb.cdLow;
    end
  end

  always_comb begin
    nextOt  = strb.overShut | (otLatch & ~strb.bothLow);
    nextOl  = strb.anyOc | (olLatch & ~strb.rstRise & ~strb.anyUv);
    nextOtw = strb.overWarn | (otwReg & ~strb.underWarn);
    fault   = strb.anyUv | nextOt | nextOl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otLatch <= 1'b0;
      olLatch <= 1'b0;
      otwReg  <= 1'b0;
      hizEn   <= '1;
      pullEn  <= '0;
      sdN     <= 1'b1;
    end else begin
      otLatch <= nextOt;
      olLatch <= nextOl;
      otwReg  <= nextOtw;
      hizEn   <= grpLow | {NUM_BR{fault}};
      pullEn  <= grpLow & {NUM_BR{~strb.modeSe}};
      sdN     <= strb.abLow | strb.cdLow | ~fault;
    end
  end

  assign otwN = ~otwReg;

  AST_UV_ALL_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    strb.anyUv |=> (hizEn == '1)); // R3
  AST_MUTE_SD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.abLow || strb.cdLow) |=> sdN); // R9
  AST_SE_NO_PULL: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeSe |=> (pullEn == '0)); // R10
  AST_OT_HOLDS_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (otLatch && !strb.bothLow) |=> (hizEn == '1)); // R7
  AST_WARN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.overWarn |=> !otwN); // R5
  AST_OC_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    strb.anyOc |=> (hizEn == '1)); // R8
endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor
  import pg_pkg::*;
#(
  parameter int NUM_SUP  = 2,
  parameter int NUM_BR   = 4,
  parameter int TEMP_W   = 8,
  parameter int WARN_ON  = 125,
  parameter int WARN_OFF = 115,
  parameter int SHUT_ON  = 155
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               grpRstAbN,
  input  logic               grpRstCdN,
  input  logic [NUM_SUP-1:0] uvFlag,
  input  logic [TEMP_W-1:0]  tempCode,
  input  logic [NUM_BR-1:0]  ocFlag,
  input  logic               modeSe,
  output logic [NUM_BR-1:0]  hizEn,
  output logic [NUM_BR-1:0]  pullEn,
  output logic               sdN,
  output logic               otwN
);
  pgStrobe_t strb;

  pg_datapath #(
    .NUM_SUP(NUM_SUP), .NUM_BR(NUM_BR), .TEMP_W(TEMP_W),
    .WARN_ON(WARN_ON), .WARN_OFF(WARN_OFF), .SHUT_ON(SHUT_ON)
  ) uDp (
    .clk(clk), .rstN(rstN), .grpRstAbN(grpRstAbN), .grpRstCdN(grpRstCdN),
    .uvFlag(uvFlag), .ocFlag(ocFlag), .tempCode(tempCode), .modeSe(modeSe),
    .strb(strb)
  );

  pg_control #(.NUM_BR(NUM_BR)) uCtl (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hizEn(hizEn), .pullEn(pullEn), .sdN(sdN), .otwN(otwN)
  );
endmodule

// File: tb/pg_supervisor_test.sv
module pg_supervisor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grpRstAbN = 1'b1, grpRstCdN = 1'b1, modeSe = 1'b0;
  logic [1:0] uvFlag = 2'b00;
  logic [7:0] tempCode = 8'd25;
  logic [3:0] ocFlag = 4'h0;
  logic [3:0] hizEn, pullEn;
  logic sdN, otwN;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] hiz;
    logic [3:0] pull;
    logic       sd;
    logic       otw;
    string      tag;
  } item_t;
  item_t sbQ[$];
  int age = 0;

  always #2.5 clk = ~clk;

  pg_supervisor uut (
    .clk(clk), .rstN(rstN), .grpRstAbN(grpRstAbN), .grpRstCdN(grpRstCdN),
    .uvFlag(uvFlag), .tempCode(tempCode), .ocFlag(ocFlag), .modeSe(modeSe),
    .hizEn(hizEn), .pullEn(pullEn), .sdN(sdN), .otwN(otwN)
  );

  task automatic compare(input item_t e);
    checks++;
    if (hizEn !== e.hiz || pullEn !== e.pull || sdN !== e.sd || otwN !== e.otw) begin
      errors++;
      $display("FAIL %s: got hiz=%h pull=%h sd=%b otw=%b, expected hiz=%h pull=%h sd=%b otw=%b",
               e.tag, hizEn, pullEn, sdN, otwN, e.hiz, e.pull, e.sd, e.otw);
    end
  endtask

  // monitor: each queued expectation is compared after the inputs settle
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        age++;
        if (age == 5) begin
          compare(sbQ[0]);
          void'(sbQ.pop_front());
          age = 0;
        end
      end
    end
  end

  task automatic step(input logic ab, input logic cd, input logic [1:0] uv,
                      input logic [7:0] t, input logic [3:0] oc, input logic se,
                      input logic [3:0] eh, input logic [3:0] ep, input logic es,
                      input logic eo, input string tag);
    item_t it;
    @(negedge clk);
    grpRstAbN = ab; grpRstCdN = cd; uvFlag = uv; tempCode = t; ocFlag = oc; modeSe = se;
    it.hiz = eh; it.pull = ep; it.sd = es; it.otw = eo; it.tag = tag;
    sbQ.push_back(it);
    while (sbQ.size() > 0) @(posedge clk);
  endtask

  initial begin
    item_t r;
    repeat (3) @(negedge clk);
    r.hiz = 4'hF; r.pull = 4'h0; r.sd = 1'b1; r.otw = 1'b1; r.tag = "R11 reset state";
    compare(r);
    rstN = 1'b1;
    step(1,1,2'b00, 25,4'h0,0, 4'h0,4'h0,1,1, "R1 idle release");
    step(0,1,2'b00, 25,4'h0,0, 4'h3,4'h3,1,1, "R1 A/B mute bridged");
    step(1,0,2'b00, 25,4'h0,0, 4'hC,4'hC,1,1, "R2 C/D mute bridged");
    step(1,0,2'b00, 25,4'h0,1, 4'hC,4'h0,1,1, "R10 single-ended no pulldown");
    step(1,1,2'b00, 25,4'h0,0, 4'h0,4'h0,1,1, "R2 unmute");
    step(1,1,2'b01, 25,4'h0,0, 4'hF,4'h0,0,1, "R3 undervoltage supply 0");
    step(1,1,2'b10, 25,4'h0,0, 4'hF,4'h0,0,1, "R3 undervoltage supply 1");
    step(1,1,2'b00, 25,4'h0,0, 4'h0,4'h0,1,1, "R4 undervoltage recovery");
    step(1,1,2'b00,130,4'h0,0, 4'h0,4'h0,1,0, "R5 warning set");
    step(1,1,2'b00,120,4'h0,0, 4'h0,4'h0,1,0, "R5 warning hysteresis hold");
    step(1,1,2'b00,115,4'h0,0, 4'h0,4'h0,1,1, "R5 warning release");
    step(1,1,2'b00,160,4'h0,0, 4'hF,4'h0,0,0, "R6 thermal shutdown");
    step(1,1,2'b00,100,4'h0,0, 4'hF,4'h0,0,1, "R6 thermal latch holds");
    step(0,1,2'b00,100,4'h0,0, 4'hF,4'h3,1,1, "R9 mute forces sd high");
    step(1,1,2'b00,100,4'h0,0, 4'hF,4'h0,0,1, "R7 single reset no clear");
    step(0,0,2'b00,100,4'h0,0, 4'hF,4'hF,1,1, "R7 both resets low");
    step(1,1,2'b00,100,4'h0,0, 4'h0,4'h0,1,1, "R7 thermal latch cleared");
    step(1,1,2'b00, 25,4'h4,0, 4'hF,4'h0,0,1, "R8 overload set");
    step(1,1,2'b00, 25,4'h0,0, 4'hF,4'h0,0,1, "R8 overload held");
    step(1,0,2'b00, 25,4'h0,0, 4'hF,4'hC,1,1, "R9 mute during overload");
    step(1,1,2'b00, 25,4'h0,0, 4'h0,4'h0,1,1, "R8 reset rising edge clears");
    step(1,1,2'b00, 25,4'h1,0, 4'hF,4'h0,0,1, "R8 overload bridge 0");
    step(1,1,2'b00, 25,4'h0,0, 4'hF,4'h0,0,1, "R8 overload held again");
    step(1,1,2'b01, 25,4'h0,0, 4'hF,4'h0,0,1, "R4 undervoltage during overload");
    step(1,1,2'b00, 25,4'h0,0, 4'h0,4'h0,1,1, "R4 undervoltage cleared overload");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule